// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block keeps recently used page table entries close to the load/store path. It covers a 32-bit virtual space with 4 KB pages. A lookup presents a 20-bit virtual page number and a 12-bit page offset. In the same cycle the block answers with a hit or a miss. On a hit it also returns the physical address and the permission bits of the cached entry. The block holds 64 entries, arranged as 16 sets of four ways. The low bits of the page number choose the set, and the remaining bits are compared against all four stored tags in parallel.

On a miss, an external page walker fetches the entry and writes it back through the fill port. Software can clear entries in two ways. A task-switch flush drops every entry that is not marked global in one cycle. A single-entry invalidate drops the entry for one page number. Lookups are combinational from the stored state. Fills, flushes and invalidates update that state at the next rising clock edge.

Top module: `xlat_tlb`

## Requirements
- R1: After synchronous reset every entry is empty, so every lookup misses.
- R2: While `lk_valid` is high, exactly one of `lk_hit` and `lk_miss` is high. While it is low, both are low.
- R3: The set is `vpn[3:0]` and the tag is `vpn[19:4]`. Each set holds four independent ways, so four different tags in one set can all be cached at once without disturbing other sets.
- R4: On a hit, `lk_pa` is `{pte[31:12], lk_off}` and `lk_flags` is `pte[11:0]` of the cached entry.
- R5: A fill whose entry has bit 0 (present) clear is ignored.
- R6: A fill for a page number that is already cached overwrites that entry in place. Nothing else in the set is disturbed.
- R7: A fill for a page number that is not cached goes into the lowest-numbered empty way of its set, if the set has one. The replacement pointer does not move.
- R8: When all four ways of the set are occupied, a fill replaces the way chosen by that set's pointer. The pointer is 0 after reset and advances by one, modulo 4, after each such replacement.
- R9: `flush_task` empties every entry whose bit 8 (global) is clear and keeps every entry whose bit 8 is set.
- R10: `inv_en` empties the entry for `inv_vpn` only, if it is cached.
- R11: A fill presented in the same cycle as a flush or an invalidate is dropped. A flush and an invalidate in the same cycle both take effect.
- R12: Lookups reflect storage combinationally. A fill, flush or invalidate becomes visible only after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_off | input | 12 | Page offset passed through to the physical address |
| lk_hit | output | 1 | Lookup found a valid entry |
| lk_miss | output | 1 | Lookup found no entry; request a walk |
| lk_pa | output | 32 | Physical address on a hit |
| lk_flags | output | 12 | Low twelve bits of the cached entry on a hit |
| fill_en | input | 1 | Write an entry returned by the walker |
| fill_vpn | input | 20 | Page number of the filled entry |
| fill_pte | input | 32 | Page table entry to store |
| flush_task | input | 1 | Drop all non-global entries |
| inv_en | input | 1 | Drop one entry |
| inv_vpn | input | 20 | Page number to drop |

## Verification
The bench goes after the replacement order inside one set. It fills four ways and then evicts twice. It then opens a hole with an invalidate and fills twice more. This shows that the hole is reused without moving the pointer, and that the next eviction lands on the way the pointer still names. A design that ignored empty ways, or advanced the pointer on every fill, would evict a different page, and a later lookup would hit where a miss is expected.

Refilling a cached page checks for duplicates and silent evictions. Flushing a mix of global and non-global pages shows whether the global bit is honoured. Same-cycle fill/flush and fill/invalidate pairs expose a wrong precedence as a stale hit. Randomized traffic over a small page pool keeps the sets under contention, and each lookup is compared against a reference model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VPN_W       = 20;
    localparam int OFF_W       = 12;
    localparam int PTE_W       = 32;
    localparam int SET_W       = 4;
    localparam int WAYS        = 4;
    localparam int SETS        = 1 << SET_W;
    localparam int TAG_W       = VPN_W - SET_W;
    localparam int WAY_W       = $clog2(WAYS);
    localparam int PPN_W       = PTE_W - OFF_W;
    localparam int PTE_PRESENT = 0;
    localparam int PTE_GLOBAL  = 8;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [SET_W-1:0] set_idx_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [WAY_W-1:0] way_t;
    typedef logic [PTE_W-1:0] pte_t;

    typedef struct packed {
        logic valid;
        tag_t tag;
        pte_t pte;
    } tlb_entry_t;

    typedef enum logic [1:0] {
        PLACE_NONE  = 2'd0,
        PLACE_MATCH = 2'd1,
        PLACE_FREE  = 2'd2,
        PLACE_EVICT = 2'd3
    } place_kind_e;

    function automatic set_idx_t vpn_set(input vpn_t v);
        return v[SET_W-1:0];
    endfunction

    function automatic tag_t vpn_tag(input vpn_t v);
        return v[VPN_W-1:SET_W];
    endfunction
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match
    import tlb_pkg::*;
#(
    parameter int N_WAYS = WAYS
) (
    input  logic [N_WAYS-1:0]            way_valid,
    input  logic [N_WAYS-1:0][TAG_W-1:0] way_tag,
    input  tag_t                         probe_tag,
    output logic [N_WAYS-1:0]            hit_vec,
    output logic                         hit_any,
    output way_t                         hit_way
);
    genvar g;
    generate
        for (g = 0; g < N_WAYS; g++) begin : g_cmp
            assign hit_vec[g] = way_valid[g] && (way_tag[g] == probe_tag);
        end
    endgenerate

    assign hit_any = |hit_vec;

    always_comb begin
        hit_way = '0;
        for (int w = N_WAYS - 1; w >= 0; w--) begin
            if (hit_vec[w]) hit_way = way_t'(w);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int N_WAYS = WAYS
) (
    input  logic [N_WAYS-1:0] way_valid,
    input  logic              match_any,
    input  way_t              match_way,
    input  way_t              rr_ptr,
    output way_t              pick_way,
    output place_kind_e       pick_kind
);
    logic free_any;
    way_t free_way;

    always_comb begin
        free_any = 1'b0;
        free_way = '0;
        for (int w = N_WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                free_any = 1'b1;
                free_way = way_t'(w);
            end
        end
    end

    always_comb begin
        if (match_any) begin
            pick_way  = match_way;
            pick_kind = PLACE_MATCH;
        end else if (free_any) begin
            pick_way  = free_way;
            pick_kind = PLACE_FREE;
        end else begin
            pick_way  = rr_ptr;
            pick_kind = PLACE_EVICT;
        end
    end
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import tlb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        lk_valid,
    input  logic [19:0] lk_vpn,
    input  logic [11:0] lk_off,
    output logic        lk_hit,
    output logic        lk_miss,
    output logic [31:0] lk_pa,
    output logic [11:0] lk_flags,
    input  logic        fill_en,
    input  logic [19:0] fill_vpn,
    input  logic [31:0] fill_pte,
    input  logic        flush_task,
    input  logic        inv_en,
    input  logic [19:0] inv_vpn
);
    tlb_entry_t [WAYS-1:0] mem [SETS];
    way_t                  rr  [SETS];

    // three probe ports: lookup, fill, invalidate
    localparam int N_PROBE = 3;
    localparam int PR_LK   = 0;
    localparam int PR_FILL = 1;
    localparam int PR_INV  = 2;

    vpn_t                  probe_vpn [N_PROBE];
    set_idx_t              probe_set [N_PROBE];
    logic [WAYS-1:0]            pv    [N_PROBE];
    logic [WAYS-1:0][TAG_W-1:0] pt    [N_PROBE];
    logic [WAYS-1:0]       p_hitvec  [N_PROBE];
    logic                  p_any     [N_PROBE];
    way_t                  p_way     [N_PROBE];

    assign probe_vpn[PR_LK]   = lk_vpn;
    assign probe_vpn[PR_FILL] = fill_vpn;
    assign probe_vpn[PR_INV]  = inv_vpn;

    genvar gp;
    generate
        for (gp = 0; gp < N_PROBE; gp++) begin : g_probe
            assign probe_set[gp] = vpn_set(probe_vpn[gp]);
            always_comb begin
                for (int w = 0; w < WAYS; w++) begin
                    pv[gp][w] = mem[probe_set[gp]][w].valid;
                    pt[gp][w] = mem[probe_set[gp]][w].tag;
                end
            end
            tlb_way_match #(.N_WAYS(WAYS)) u_match (
                .way_valid (pv[gp]),
                .way_tag   (pt[gp]),
                .probe_tag (vpn_tag(probe_vpn[gp])),
                .hit_vec   (p_hitvec[gp]),
                .hit_any   (p_any[gp]),
                .hit_way   (p_way[gp])
            );
        end
    endgenerate

    // lookup result
    tlb_entry_t lk_ent;
    assign lk_ent   = mem[probe_set[PR_LK]][p_way[PR_LK]];
    assign lk_hit   = lk_valid && p_any[PR_LK];
    assign lk_miss  = lk_valid && !p_any[PR_LK];
    assign lk_pa    = {lk_ent.pte[PTE_W-1:OFF_W], lk_off};
    assign lk_flags = lk_ent.pte[OFF_W-1:0];

    // fill placement
    way_t        fill_way;
    place_kind_e fill_kind;
    logic        fill_ok;

    tlb_victim #(.N_WAYS(WAYS)) u_victim (
        .way_valid (pv[PR_FILL]),
        .match_any (p_any[PR_FILL]),
        .match_way (p_way[PR_FILL]),
        .rr_ptr    (rr[probe_set[PR_FILL]]),
        .pick_way  (fill_way),
        .pick_kind (fill_kind)
    );

    assign fill_ok = fill_en && fill_pte[PTE_PRESENT] && !flush_task && !inv_en;

    tlb_entry_t fill_ent;
    assign fill_ent = '{valid: 1'b1, tag: vpn_tag(fill_vpn), pte: fill_pte};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                mem[s] <= '0;
                rr[s]  <= '0;
            end
        end else begin
            if (flush_task) begin
                for (int s = 0; s < SETS; s++) begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (!mem[s][w].pte[PTE_GLOBAL]) mem[s][w].valid <= 1'b0;
                    end
                end
            end
            if (inv_en && p_any[PR_INV]) begin
                mem[probe_set[PR_INV]][p_way[PR_INV]].valid <= 1'b0;
            end
            if (fill_ok) begin
                mem[probe_set[PR_FILL]][fill_way] <= fill_ent;
                if (fill_kind == PLACE_EVICT) begin
                    rr[probe_set[PR_FILL]] <= rr[probe_set[PR_FILL]] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
    import tlb_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        lk_valid,
    input logic [19:0] lk_vpn,
    input logic [11:0] lk_off,
    input logic        lk_hit,
    input logic        lk_miss,
    input logic [31:0] lk_pa,
    input logic [11:0] lk_flags,
    input logic        fill_en,
    input logic [19:0] fill_vpn,
    input logic [31:0] fill_pte,
    input logic        flush_task,
    input logic        inv_en,
    input logic [19:0] inv_vpn
);
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !lk_hit);

    p_one_answer_r2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> (lk_hit ^ lk_miss));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> (!lk_hit && !lk_miss));

    p_offset_pass_r4: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_pa[OFF_W-1:0] == lk_off));

    p_present_only_r5: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_flags[PTE_PRESENT]);

    p_fill_visible_r12: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !$past(rst) && $past(fill_en && fill_pte[PTE_PRESENT] && !flush_task && !inv_en)
         && lk_vpn == $past(fill_vpn))
        |-> (lk_hit && lk_pa[31:12] == $past(fill_pte[31:12])));

    p_inv_gone_r10: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !$past(rst) && $past(inv_en) && lk_vpn == $past(inv_vpn)) |-> !lk_hit);

    p_flush_keeps_global_r9: assert property (@(posedge clk) disable iff (rst)
        (lk_hit && !$past(rst) && $past(flush_task)) |-> lk_flags[PTE_GLOBAL]);
endmodule

bind xlat_tlb tlb_checker u_chk (.*);

// File: tb/sim_xlat_tlb.sv
`timescale 1ns/1ps
module sim_xlat_tlb;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid;
    logic [19:0] lk_vpn;
    logic [11:0] lk_off;
    logic        lk_hit, lk_miss;
    logic [31:0] lk_pa;
    logic [11:0] lk_flags;
    logic        fill_en;
    logic [19:0] fill_vpn;
    logic [31:0] fill_pte;
    logic        flush_task;
    logic        inv_en;
    logic [19:0] inv_vpn;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    xlat_tlb u0 (.*);

    // reference model
    logic        m_v [16][4];
    logic [15:0] m_t [16][4];
    logic [31:0] m_p [16][4];
    int          m_rr[16];

    function automatic void model_reset();
        for (int s = 0; s < 16; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < 4; w++) begin
                m_v[s][w] = 1'b0; m_t[s][w] = '0; m_p[s][w] = '0;
            end
        end
    endfunction

    function automatic int model_find(input logic [19:0] v);
        for (int w = 0; w < 4; w++)
            if (m_v[v[3:0]][w] && m_t[v[3:0]][w] == v[19:4]) return w;
        return -1;
    endfunction

    function automatic void model_step(input logic fe, input logic [19:0] fv, input logic [31:0] fp,
                                       input logic ie, input logic [19:0] iv, input logic fl);
        int w;
        int s;
        if (fl)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 4; b++)
                    if (!m_p[a][b][8]) m_v[a][b] = 1'b0;
        if (ie) begin
            w = model_find(iv);
            if (w >= 0) m_v[iv[3:0]][w] = 1'b0;
        end
        if (fe && fp[0] && !fl && !ie) begin
            s = int'(fv[3:0]);
            w = model_find(fv);
            if (w < 0)
                for (int b = 3; b >= 0; b--) if (!m_v[s][b]) w = b;
            if (w < 0) begin
                w = m_rr[s];
                m_rr[s] = (m_rr[s] + 1) % 4;
            end
            m_v[s][w] = 1'b1; m_t[s][w] = fv[19:4]; m_p[s][w] = fp;
        end
    endfunction

    task automatic check_lookup(input logic lv, input logic [19:0] v, input logic [11:0] off, input string req);
        int w;
        logic        eh;
        logic [31:0] epa;
        logic [11:0] efl;
        checks++;
        if (!lv) begin
            if (lk_hit || lk_miss) begin
                errors++;
                $display("FAIL %s idle: hit=%0b miss=%0b expected 0 0", req, lk_hit, lk_miss);
            end
            return;
        end
        w = model_find(v);
        eh = (w >= 0);
        if (eh) begin
            epa = {m_p[v[3:0]][w][31:12], off};
            efl = m_p[v[3:0]][w][11:0];
        end else begin
            epa = '0; efl = '0;
        end
        if (lk_hit !== eh || lk_miss !== !eh ||
            (eh && (lk_pa !== epa || lk_flags !== efl))) begin
            errors++;
            $display("FAIL %s vpn=%05h: hit=%0b miss=%0b pa=%08h fl=%03h expected hit=%0b pa=%08h fl=%03h",
                     req, v, lk_hit, lk_miss, lk_pa, lk_flags, eh, epa, efl);
        end
    endtask

    task automatic step(input logic lv, input logic [19:0] lv_vpn, input logic [11:0] loff,
                        input logic fe, input logic [19:0] fv, input logic [31:0] fp,
                        input logic ie, input logic [19:0] iv, input logic fl, input string req);
        @(negedge clk);
        lk_valid = lv; lk_vpn = lv_vpn; lk_off = loff;
        fill_en = fe; fill_vpn = fv; fill_pte = fp;
        inv_en = ie; inv_vpn = iv; flush_task = fl;
        #1;
        check_lookup(lv, lv_vpn, loff, req);
        @(posedge clk);
        model_step(fe, fv, fp, ie, iv, fl);
    endtask

    task automatic look(input logic [19:0] v, input string req);
        step(1'b1, v, 12'h7A5, 1'b0, '0, '0, 1'b0, '0, 1'b0, req);
    endtask

    task automatic fill(input logic [19:0] v, input logic [31:0] p, input string req);
        step(1'b0, '0, '0, 1'b1, v, p, 1'b0, '0, 1'b0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        rst = 1'b1; lk_valid = 0; lk_vpn = '0; lk_off = '0; fill_en = 0; fill_vpn = '0;
        fill_pte = '0; flush_task = 0; inv_en = 0; inv_vpn = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 reset empty, R2 idle quiet
        look(20'h00005, "R1");
        look(20'h12345, "R1");
        step(1'b0, '0, '0, 1'b0, '0, '0, 1'b0, '0, 1'b0, "R2");

        // R12 fill not visible in its own cycle, visible after the edge; R4 fields
        step(1'b1, 20'h12345, 12'h3C1, 1'b1, 20'h12345, 32'hABCDE_063, 1'b0, '0, 1'b0, "R12");
        step(1'b1, 20'h12345, 12'hFFF, 1'b0, '0, '0, 1'b0, '0, 1'b0, "R4");

        // R5 not-present fill ignored
        fill(20'h00335, 32'h11111_002, "R5");
        look(20'h00335, "R5");

        // R3 four tags in set 9, plus same tag in set A
        fill(20'h00019, 32'h10001_003, "R3");
        fill(20'h00029, 32'h10002_003, "R3");
        fill(20'h00039, 32'h10003_003, "R3");
        fill(20'h00049, 32'h10004_003, "R3");
        fill(20'h0001A, 32'h20001_007, "R3");
        look(20'h00019, "R3"); look(20'h00029, "R3");
        look(20'h00039, "R3"); look(20'h00049, "R3");
        look(20'h0001A, "R3"); look(20'h12345, "R3");

        // R6 refill in place
        fill(20'h00029, 32'h3CAFE_067, "R6");
        look(20'h00029, "R6"); look(20'h00019, "R6"); look(20'h00049, "R6");

        // R8 round-robin eviction: way0 then way1
        fill(20'h00059, 32'h10005_003, "R8");
        look(20'h00019, "R8"); look(20'h00059, "R8");
        fill(20'h00069, 32'h10006_003, "R8");
        look(20'h00029, "R8"); look(20'h00039, "R8");

        // R10 invalidate one entry; R7 hole reused without moving pointer
        step(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 20'h00039, 1'b0, "R10");
        look(20'h00039, "R10"); look(20'h00049, "R10"); look(20'h00059, "R10");
        fill(20'h00079, 32'h10007_003, "R7");
        look(20'h00079, "R7"); look(20'h00049, "R7");
        fill(20'h00089, 32'h10008_003, "R8");
        look(20'h00079, "R8"); look(20'h00049, "R8"); look(20'h00089, "R8");

        // R9 flush keeps global entries
        fill(20'h00777, 32'h77777_103, "R9");
        fill(20'h00888, 32'h88888_003, "R9");
        step(1'b0, '0, '0, 1'b0, '0, '0, 1'b0, '0, 1'b1, "R9");
        look(20'h00777, "R9"); look(20'h00888, "R9"); look(20'h12345, "R9");

        // R11 precedence
        step(1'b0, '0, '0, 1'b1, 20'h00AAA, 32'hAAAAA_103, 1'b0, '0, 1'b1, "R11");
        look(20'h00AAA, "R11");
        step(1'b0, '0, '0, 1'b1, 20'h00BBB, 32'hBBBBB_003, 1'b1, 20'h00777, 1'b0, "R11");
        look(20'h00BBB, "R11"); look(20'h00777, "R11");
        fill(20'h00CCC, 32'hCCCCC_103, "R11");
        step(1'b0, '0, '0, 1'b0, '0, '0, 1'b1, 20'h00CCC, 1'b1, "R11");
        look(20'h00CCC, "R11");

        // randomized traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [19:0] rv, fvr, ivr;
            logic [31:0] fpr;
            logic        fe, ie, fl, lv;
            rv  = {16'($urandom_range(0, 5)), 4'($urandom_range(0, 3))};
            fvr = {16'($urandom_range(0, 5)), 4'($urandom_range(0, 3))};
            ivr = {16'($urandom_range(0, 5)), 4'($urandom_range(0, 3))};
            fpr = $urandom;
            fpr[0] = ($urandom_range(0, 9) != 0);
            fe  = ($urandom_range(0, 9) < 4);
            ie  = ($urandom_range(0, 19) == 0);
            fl  = ($urandom_range(0, 49) == 0);
            lv  = ($urandom_range(0, 7) != 0);
            step(lv, rv, 12'($urandom), fe, fvr, fpr, ie, ivr, fl, "R8/R4 random");
        end

        @(negedge clk);
        lk_valid = 0; fill_en = 0; inv_en = 0; flush_task = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule